// File: doc/BRIEF.md
# Detection Bitmap Writer

This block keeps a one-bit-per-cell map of threshold detections for the current frame. The map is held in a single-port memory addressed by range and Doppler cell. Each incoming detection is merged into its cell through a read-modify-write sequence. The previous contents of the cell and the new detection bit are ORed together, so a cell that was set once stays set for the rest of the frame.

A frame-boundary pulse opens the filling window and starts a sweep that writes zero to every cell, one cell per clock, beginning at address 0. Detections are taken only while the window is open and no sweep is running.

An update occupies the memory port for three cycles, so the block cannot take detections on consecutive cycles. A detection that arrives while an update is still in flight is not merged into the map. Instead, the block raises a one-cycle collision pulse and increments a saturating counter. When neither an update nor a sweep is running, the memory port serves a simple read port, which a downstream reader uses to stream the map out.

Top module: `detmap_writer`

## Requirements
- R1: After reset, `drop_pulse` is 0, `drop_count` is 0 and `clearing` is 0. The filling window is closed, so detections presented before the first `frame_done` change nothing, even when presented on every cycle: `drop_count` stays 0.
- R2: A detection with range index r and Doppler index d updates the cell at address {r, d}. The range index forms the upper (slow) address bits and the Doppler index forms the lower (fast) bits.
- R3: An update stores the OR of the old cell value and `det_hit`. A detection with `det_hit`=0 leaves the cell unchanged, and a cell that is already set stays set.
- R4: An accepted detection keeps the update logic busy for exactly three cycles: idle, read-wait and write-back. Detections spaced three cycles apart are all merged, and none is rejected.
- R5: A valid detection inside the window that arrives in either of the two cycles after an accepted one is rejected. It leaves the map untouched and raises `drop_pulse` for one cycle, in the cycle after it was presented. With detections on every second cycle, they are alternately merged and rejected.
- R6: `drop_count` (8 bits by default) increases by one for each rejection. It holds at its all-ones value rather than wrapping.
- R7: One cycle after `frame_done`, `clearing` is 1. It stays 1 for exactly 2^(RANGE_W+DOPP_W) cycles, and afterwards every cell reads 0.
- R8: Detections presented while `clearing` is 1 are ignored. They are not written and they are not counted as rejections.
- R9: When neither a sweep nor an update is in progress, `rd_data` presents the cell at `rd_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | Frame boundary pulse: opens the window, starts the clear sweep |
| det_valid | input | 1 | Detection strobe |
| det_hit | input | 1 | Detection bit to merge |
| det_range | input | RANGE_W | Range index (upper address part) |
| det_dopp | input | DOPP_W | Doppler index (lower address part) |
| rd_addr | input | RANGE_W+DOPP_W | Readout address |
| rd_data | output | 1 | Cell value, one cycle after `rd_addr` |
| clearing | output | 1 | Clear sweep in progress |
| drop_pulse | output | 1 | One-cycle pulse per rejected detection |
| drop_count | output | CNT_W | Saturating count of rejections |

## Verification
Some properties are checked by assertions on every cycle:
- the fixed read-wait to write-back progression;
- that a drop pulse always follows a valid that met a busy update;
- that the counter never moves without a pulse and never wraps;
- that a frame boundary always starts the sweep at address 0;
- that no update starts during a sweep.

Other behaviours show only in the bench's scenarios, which read the whole map back against a reference bitmap:
- the address layout;
- the OR merge;
- the exact alternation of merges and drops under two- and three-cycle spacing;
- the length of the sweep;
- the absence of writes from detections ignored during a sweep.

// File: rtl/detmap_writer.sv
module detmap_writer #(
  parameter int RANGE_W = 5,
  parameter int DOPP_W  = 4,
  parameter int CNT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_done,
  input  logic                      det_valid,
  input  logic                      det_hit,
  input  logic [RANGE_W-1:0]        det_range,
  input  logic [DOPP_W-1:0]         det_dopp,
  input  logic [RANGE_W+DOPP_W-1:0] rd_addr,
  output logic                      rd_data,
  output logic                      clearing,
  output logic                      drop_pulse,
  output logic [CNT_W-1:0]          drop_count
);
  localparam int ADDR_W = RANGE_W + DOPP_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WB} upd_t;

  upd_t              st;
  logic              filling;
  logic [ADDR_W-1:0] clr_ptr;
  logic [ADDR_W-1:0] upd_addr;
  logic              upd_hit;
  logic              mem [DEPTH];
  logic              mem_q;

  wire take   = det_valid && filling && !clearing && !frame_done;
  wire accept = take && (st == S_IDLE);
  wire reject = take && (st != S_IDLE);

  // single memory port: sweep, then update, then readout
  wire [ADDR_W-1:0] port_addr = clearing ? clr_ptr : (st == S_IDLE ? rd_addr : upd_addr);
  wire              port_we   = clearing || (st == S_WB);
  wire              port_wd   = !clearing && (mem_q | upd_hit);

  always_ff @(posedge clk) begin
    if (port_we) mem[port_addr] <= port_wd;
    mem_q <= mem[port_addr];
  end

  assign rd_data = mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      filling    <= 1'b0;
      clearing   <= 1'b0;
      clr_ptr    <= '0;
      upd_addr   <= '0;
      upd_hit    <= 1'b0;
      drop_pulse <= 1'b0;
      drop_count <= '0;
    end else begin
      drop_pulse <= reject;
      if (reject && drop_count != '1) drop_count <= drop_count + 1'b1;
      if (frame_done) begin
        // a frame boundary abandons any update in flight
        filling  <= 1'b1;
        clearing <= 1'b1;
        clr_ptr  <= '0;
        st       <= S_IDLE;
      end else begin
        if (clearing) begin
          clr_ptr <= clr_ptr + 1'b1;
          if (clr_ptr == '1) clearing <= 1'b0;
        end
        case (st)
          S_IDLE: if (accept) begin
            upd_addr <= {det_range, det_dopp};
            upd_hit  <= det_hit;
            st       <= S_RD;
          end
          S_RD:    st <= S_WB;
          S_WB:    st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_rd_to_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && !frame_done) |=> (st == S_WB));
  p_wb_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |=> (st == S_IDLE));
  p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> ($past(det_valid) && $past(st) != S_IDLE && !$past(clearing)));
  p_count_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_pulse && drop_count == $past(drop_count) + 1'b1));
  p_count_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == '1) |=> (drop_count == '1));
  p_sweep_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (clearing && clr_ptr == '0));
  p_no_update_in_sweep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |=> (st == S_IDLE));
  p_no_drop_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !filling |=> !drop_pulse);
endmodule

// File: tb/test_detmap_writer.sv
`timescale 1ns/1ps
module test_detmap_writer;
  localparam int RW = 5, DW = 4, CW = 8;
  localparam int AW = RW + DW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, frame_done = 1'b0;
  logic det_valid = 1'b0, det_hit = 1'b0;
  logic [RW-1:0] det_range = '0;
  logic [DW-1:0] det_dopp = '0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_data, clearing, drop_pulse;
  logic [CW-1:0] drop_count;

  int n_cmp = 0, n_bad = 0, n_pulse = 0, exp_drops = 0;
  bit ref_map [DEPTH];

  always #2.5 clk = ~clk;

  detmap_writer #(.RANGE_W(RW), .DOPP_W(DW), .CNT_W(CW)) i_detmap_writer (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .det_valid(det_valid),
    .det_hit(det_hit), .det_range(det_range), .det_dopp(det_dopp),
    .rd_addr(rd_addr), .rd_data(rd_data), .clearing(clearing),
    .drop_pulse(drop_pulse), .drop_count(drop_count));

  always @(negedge clk) if (rst_n && drop_pulse) n_pulse++;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit h, int r, int d);
    @(negedge clk);
    det_valid = v; det_hit = h; det_range = RW'(r); det_dopp = DW'(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic put(bit h, int r, int d);
    if (h) ref_map[{RW'(r), DW'(d)}] = 1'b1;
  endtask

  task automatic start_frame(bit check_len);
    int len;
    @(negedge clk); frame_done = 1'b1; det_valid = 1'b0;
    @(negedge clk); frame_done = 1'b0;
    check("R7 sweep starts", clearing, 1);
    len = 0;
    while (clearing) begin len++; @(negedge clk); end
    if (check_len) check("R7 sweep length", len, DEPTH);
    for (int a = 0; a < DEPTH; a++) ref_map[a] = 1'b0;
  endtask

  task automatic readback(string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); rd_addr = AW'(a);
      @(negedge clk); check(req, rd_data, ref_map[a]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 drop_pulse reset", drop_pulse, 0);
    check("R1 drop_count reset", drop_count, 0);
    check("R1 clearing reset", clearing, 0);

    // R1: window closed before first frame boundary
    for (int i = 0; i < 12; i++) cyc(1, 1, i, i);
    idle(3);
    check("R1 closed window", drop_count, 0);

    // R7: full sweep then an all-zero map
    start_frame(1);
    readback("R7 map cleared");

    // R4 / R2 / R3: one detection every third cycle
    for (int i = 0; i < 90; i++) begin
      int r = (i * 11) % 32, d = (i * 7) % 16;
      bit h = (i % 5) != 0;
      cyc(1, h, r, d); put(h, r, d);
      idle(2);
    end
    // R3: hit=0 on a set cell and hit=1 twice on the same cell
    cyc(1, 0, 11, 7); idle(2);
    cyc(1, 1, 31, 15); put(1, 31, 15); idle(2);
    cyc(1, 1, 31, 15); idle(4);
    check("R4 no drops at 3-cycle spacing", drop_count, 0);
    check("R4 no drop pulses", n_pulse, 0);
    readback("R2 R3 map contents");

    // R5: one detection every second cycle, alternately merged and dropped
    start_frame(0);
    for (int i = 0; i < 40; i++) begin
      int r = (i * 3) % 32, d = (i * 5) % 16;
      cyc(1, 1, r, d);
      if (i % 2 == 0) put(1, r, d); else exp_drops++;
      idle(1);
    end
    idle(4);
    check("R5 drop pulses", n_pulse, exp_drops);
    check("R6 drop count", drop_count, exp_drops);
    readback("R5 dropped cells untouched");

    // R8: detections during a sweep are neither written nor counted
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, i % 4);
    det_valid = 1'b0;
    while (clearing) @(negedge clk);
    for (int a = 0; a < DEPTH; a++) ref_map[a] = 1'b0;
    idle(3);
    check("R8 no drops in sweep", drop_count, exp_drops);
    readback("R8 R9 map after sweep");

    // R6: valid on every cycle drives the counter to saturation
    for (int i = 0; i < 600; i++) begin
      cyc(1, 1, i % 32, i % 16);
      if (i % 3 != 0) exp_drops++;
    end
    idle(4);
    check("R6 pulses every cycle", n_pulse, exp_drops);
    check("R6 saturated", drop_count, (exp_drops > 255) ? 255 : exp_drops);
    idle(10);
    check("R6 holds", drop_count, 255);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule